// File: doc/BRIEF.md
# Scrub Supervisor State Sequencer

This block is the control core of a supervisor that scrubs configuration memory. It comes out of a synchronous reset and runs a one-time initialization. It then waits in observation and watches four detection inputs: ECC error, single-bit flag, syndrome valid and CRC error. When it sees an error it records what kind of error it is. It then visits a correction step and a classification step, in that order, and goes back to observation. The real correction, classification, initialization and injection work is done by sub-engines. Each sub-engine is driven through a level request and a done reply. Correction also returns a success bit, and classification returns a hit bit that marks an essential location.

Five status outputs name the active state, and each one is high alone. All five low means the sequencer is idle. All five high means it has halted after a sub-engine reported a fatal error. Only reset leaves the halted state. A request input moves the sequencer from observation to idle. In idle it accepts single-bit injection commands, each carrying a 36-bit target address. While observing, a heartbeat output pulses for one cycle out of every 128 so that outside logic can run a watchdog on it. Two qualifier flags report whether the last error could not be corrected and whether it touched an essential bit. When the correction or classification feature is compiled out, the state is still visited for exactly one cycle.

States: SQ_INIT, SQ_OBSERVE, SQ_CORRECT, SQ_CLASSIFY, SQ_IDLE, SQ_INJECT, SQ_HALT.

Transitions:
- INIT→OBSERVE on init_done.
- OBSERVE→CORRECT on a detected error.
- OBSERVE→IDLE on idle_req.
- CORRECT→CLASSIFY when correction passes.
- CLASSIFY→OBSERVE when classification passes.
- IDLE→INJECT on inj_strobe.
- IDLE→OBSERVE when idle_req is low.
- INJECT→IDLE on inj_done.
- INIT, CORRECT, CLASSIFY or INJECT → HALT on eng_fault.

Top module: `scrub_sequencer`

## Requirements
- R1: The status vector {st_init, st_observe, st_correct, st_classify, st_inject} has exactly one bit high in an active state. It is all zeros in idle and all ones in halt.
- R2: After reset the sequencer is in initialization with init_req high. It moves to observation in the cycle after init_done, and it never returns to initialization without a reset.
- R3: In observation, heartbeat is a one-cycle pulse from a free-running 7-bit counter when the counter wraps, so any 512 consecutive observing cycles hold exactly 4 pulses. Heartbeat is low in every other state.
- R4: inj_strobe is honoured only in idle. inj_addr is captured in that same cycle and held on inj_addr_q. A strobe in any other state leaves inj_addr_q and the state unchanged.
- R5: st_inject and inj_req are high from the cycle after an accepted strobe until the cycle after inj_done. The sequencer then returns to idle.
- R6: In observation, an error, meaning (ecc_err AND syn_valid) OR crc_err, moves the sequencer to correction on the next cycle. An error takes priority over idle_req. No other combination of detection inputs leaves observation.
- R7: With correction enabled, and unless the error is CRC-only, cor_req stays high in correction until cor_done. flag_uncorr is then set to NOT cor_ok, and it is valid from the first classification cycle.
- R8: A CRC-only error (crc_err without ecc_err AND syn_valid) passes correction and classification in one cycle each without requesting either engine. It sets flag_uncorr to 1 and flag_essential to 1.
- R9: With a feature disabled, its state lasts exactly one cycle. Disabled correction gives flag_uncorr = 1, and disabled classification gives flag_essential = 1.
- R10: With classification enabled, and unless the error is CRC-only, cls_req stays high until cls_done. flag_essential is then set to cls_hit, and the sequencer is back in observation on the next cycle.
- R11: idle_req in observation, with no error, moves the sequencer to idle. In idle, with idle_req low and no strobe, it moves back to observation.
- R12: eng_fault in initialization, correction, classification or injection moves the sequencer to halt. Halt ignores every input until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| det_ecc_err | input | 1 | Frame ECC error seen |
| det_ecc_single | input | 1 | ECC syndrome indicates one bit |
| det_syn_valid | input | 1 | Syndrome valid qualifier |
| det_crc_err | input | 1 | Whole-device CRC mismatch |
| idle_req | input | 1 | Request to enter or stay in idle |
| inj_strobe | input | 1 | One-cycle injection command |
| inj_addr | input | 36 | Injection target address |
| init_done | input | 1 | Initialization engine finished |
| cor_done | input | 1 | Correction engine finished |
| cor_ok | input | 1 | Correction succeeded |
| cls_done | input | 1 | Classification engine finished |
| cls_hit | input | 1 | Corrected bit is essential |
| inj_done | input | 1 | Injection engine finished |
| eng_fault | input | 1 | Fatal sub-engine error |
| init_req | output | 1 | Initialization engine request |
| cor_req | output | 1 | Correction engine request |
| cls_req | output | 1 | Classification engine request |
| inj_req | output | 1 | Injection engine request |
| inj_addr_q | output | 36 | Captured injection address |
| evt_single | output | 1 | Captured single-bit flag of last error |
| st_init | output | 1 | Status: initialization |
| st_observe | output | 1 | Status: observation |
| st_correct | output | 1 | Status: correction |
| st_classify | output | 1 | Status: classification |
| st_inject | output | 1 | Status: injection |
| heartbeat | output | 1 | Watchdog pulse while observing |
| flag_uncorr | output | 1 | Last error uncorrectable |
| flag_essential | output | 1 | Last error essential |

## Verification
The hardest case to reach from the ports is an error seen by two builds with different feature settings, where both builds must pass through correction and classification in step. The bench runs one instance with both features enabled and one with both disabled, side by side on the same stimulus. It then sweeps all 64 combinations of the four detection inputs, cor_ok and cls_hit, so that CRC-only, ECC without syndrome valid, and every flag outcome each occur. The halt state is reached last by raising eng_fault during correction, and the bench then shows that every input is ignored there.

// File: rtl/scrub_seq_pkg.sv
package scrub_seq_pkg;

    typedef enum logic [2:0] {
        SQ_INIT,
        SQ_OBSERVE,
        SQ_CORRECT,
        SQ_CLASSIFY,
        SQ_IDLE,
        SQ_INJECT,
        SQ_HALT
    } seq_state_e;

    typedef struct packed {
        logic crc_only;
        logic single;
    } err_evt_t;

endpackage

// File: rtl/scrub_beat_gen.sv
module scrub_beat_gen #(
    parameter int CNT_W = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic beat
);
    localparam int PERIOD = 1 << CNT_W;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign beat = en && (&cnt);

    // checker: cycles since the last pulse while enabled
    logic [CNT_W:0] gap;
    always_ff @(posedge clk) begin
        if (rst || !en || beat) gap <= '0;
        else                    gap <= gap + 1'b1;
    end

    AST_BEAT_PULSE: assert property (@(posedge clk) disable iff (rst)
        beat |=> !beat);                                   // R3
    AST_BEAT_GAP: assert property (@(posedge clk) disable iff (rst)
        gap < (CNT_W+1)'(PERIOD));                         // R3
endmodule

// File: rtl/scrub_verdict.sv
module scrub_verdict #(
    parameter bit COR_EN = 1'b1,
    parameter bit CLS_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic cor_exit,
    input  logic cls_exit,
    input  logic crc_only,
    input  logic cor_ok,
    input  logic cls_hit,
    output logic flag_uncorr,
    output logic flag_essential
);
    logic uncorr_val, ess_val;

    always_comb begin
        uncorr_val = !COR_EN || crc_only || !cor_ok;
        ess_val    = !CLS_EN || crc_only || cls_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_uncorr    <= 1'b0;
            flag_essential <= 1'b0;
        end else begin
            if (cor_exit) flag_uncorr    <= uncorr_val;
            if (cls_exit) flag_essential <= ess_val;
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cor_exit |=> $stable(flag_uncorr));               // R7
endmodule

// File: rtl/scrub_sequencer.sv
module scrub_sequencer
    import scrub_seq_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int BEAT_W = 7,
    parameter bit COR_EN = 1'b1,
    parameter bit CLS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              det_ecc_err,
    input  logic              det_ecc_single,
    input  logic              det_syn_valid,
    input  logic              det_crc_err,
    input  logic              idle_req,
    input  logic              inj_strobe,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic              init_done,
    input  logic              cor_done,
    input  logic              cor_ok,
    input  logic              cls_done,
    input  logic              cls_hit,
    input  logic              inj_done,
    input  logic              eng_fault,
    output logic              init_req,
    output logic              cor_req,
    output logic              cls_req,
    output logic              inj_req,
    output logic [ADDR_W-1:0] inj_addr_q,
    output logic              evt_single,
    output logic              st_init,
    output logic              st_observe,
    output logic              st_correct,
    output logic              st_classify,
    output logic              st_inject,
    output logic              heartbeat,
    output logic              flag_uncorr,
    output logic              flag_essential
);
    seq_state_e state, state_nx;
    err_evt_t   evt_q;

    logic ecc_hit, det_hit, cor_pass, cls_pass, cor_exit, cls_exit;

    always_comb begin
        ecc_hit  = det_ecc_err && det_syn_valid;
        det_hit  = ecc_hit || det_crc_err;
        cor_pass = !COR_EN || evt_q.crc_only || cor_done;
        cls_pass = !CLS_EN || evt_q.crc_only || cls_done;
        cor_exit = (state == SQ_CORRECT)  && cor_pass && !eng_fault;
        cls_exit = (state == SQ_CLASSIFY) && cls_pass && !eng_fault;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_INIT:     if (eng_fault) state_nx = SQ_HALT;
                         else if (init_done) state_nx = SQ_OBSERVE;
            SQ_OBSERVE:  if (det_hit) state_nx = SQ_CORRECT;
                         else if (idle_req) state_nx = SQ_IDLE;
            SQ_CORRECT:  if (eng_fault) state_nx = SQ_HALT;
                         else if (cor_pass) state_nx = SQ_CLASSIFY;
            SQ_CLASSIFY: if (eng_fault) state_nx = SQ_HALT;
                         else if (cls_pass) state_nx = SQ_OBSERVE;
            SQ_IDLE:     if (inj_strobe) state_nx = SQ_INJECT;
                         else if (!idle_req) state_nx = SQ_OBSERVE;
            SQ_INJECT:   if (eng_fault) state_nx = SQ_HALT;
                         else if (inj_done) state_nx = SQ_IDLE;
            SQ_HALT:     state_nx = SQ_HALT;
            default:     state_nx = SQ_HALT;
        endcase
    end

    // state register with event and address capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_INIT;
            evt_q      <= '0;
            inj_addr_q <= '0;
        end else begin
            state <= state_nx;
            if (state == SQ_OBSERVE && det_hit) begin
                evt_q.crc_only <= !ecc_hit;
                evt_q.single   <= ecc_hit && det_ecc_single;
            end
            if (state == SQ_IDLE && inj_strobe) inj_addr_q <= inj_addr;
        end
    end

    // output decode
    always_comb begin
        st_init     = 1'b0;
        st_observe  = 1'b0;
        st_correct  = 1'b0;
        st_classify = 1'b0;
        st_inject   = 1'b0;
        init_req    = 1'b0;
        cor_req     = 1'b0;
        cls_req     = 1'b0;
        inj_req     = 1'b0;
        unique case (state)
            SQ_INIT:     begin st_init = 1'b1; init_req = 1'b1; end
            SQ_OBSERVE:  st_observe = 1'b1;
            SQ_CORRECT:  begin st_correct = 1'b1; cor_req = COR_EN && !evt_q.crc_only; end
            SQ_CLASSIFY: begin st_classify = 1'b1; cls_req = CLS_EN && !evt_q.crc_only; end
            SQ_IDLE:     ;
            SQ_INJECT:   begin st_inject = 1'b1; inj_req = 1'b1; end
            SQ_HALT: begin
                st_init = 1'b1; st_observe = 1'b1; st_correct = 1'b1;
                st_classify = 1'b1; st_inject = 1'b1;
            end
            default: ;
        endcase
    end

    assign evt_single = evt_q.single;

    scrub_beat_gen #(.CNT_W(BEAT_W)) beat_i (
        .clk  (clk),
        .rst  (rst),
        .en   (st_observe && !st_init),
        .beat (heartbeat)
    );

    scrub_verdict #(.COR_EN(COR_EN), .CLS_EN(CLS_EN)) verdict_i (
        .clk            (clk),
        .rst            (rst),
        .cor_exit       (cor_exit),
        .cls_exit       (cls_exit),
        .crc_only       (evt_q.crc_only),
        .cor_ok         (cor_ok),
        .cls_hit        (cls_hit),
        .flag_uncorr    (flag_uncorr),
        .flag_essential (flag_essential)
    );

    logic [4:0] st_vec;
    assign st_vec = {st_init, st_observe, st_correct, st_classify, st_inject};

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st_vec) || (&st_vec));                                    // R1
    AST_INIT_ONCE: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_INIT) |=> (state != SQ_INIT));                        // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(state == SQ_IDLE && inj_strobe) |=> $stable(inj_addr_q));        // R4
    AST_CRC_ONLY_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_CLASSIFY && evt_q.crc_only) |-> flag_uncorr);         // R8
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_HALT) |=> (state == SQ_HALT));                        // R12
endmodule

// File: tb/scrub_sequencer_tb_top.sv
module scrub_sequencer_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic ecc = 0, single = 0, synv = 0, crc = 0, idle_r = 0, strobe = 0;
    logic [35:0] addr = '0;
    logic init_d = 0, cor_d = 0, cok = 0, cls_d = 0, chit = 0, inj_d = 0, fault = 0;

    logic a_init_req, a_cor_req, a_cls_req, a_inj_req, a_single;
    logic a_si, a_so, a_sc, a_sk, a_sj, a_hb, a_unc, a_ess;
    logic [35:0] a_addr_q;
    logic b_init_req, b_cor_req, b_cls_req, b_inj_req, b_single;
    logic b_si, b_so, b_sc, b_sk, b_sj, b_hb, b_unc, b_ess;
    logic [35:0] b_addr_q;

    scrub_sequencer dut_i (
        .clk(clk), .rst(rst), .det_ecc_err(ecc), .det_ecc_single(single),
        .det_syn_valid(synv), .det_crc_err(crc), .idle_req(idle_r),
        .inj_strobe(strobe), .inj_addr(addr), .init_done(init_d),
        .cor_done(cor_d), .cor_ok(cok), .cls_done(cls_d), .cls_hit(chit),
        .inj_done(inj_d), .eng_fault(fault), .init_req(a_init_req),
        .cor_req(a_cor_req), .cls_req(a_cls_req), .inj_req(a_inj_req),
        .inj_addr_q(a_addr_q), .evt_single(a_single), .st_init(a_si),
        .st_observe(a_so), .st_correct(a_sc), .st_classify(a_sk),
        .st_inject(a_sj), .heartbeat(a_hb), .flag_uncorr(a_unc),
        .flag_essential(a_ess));

    scrub_sequencer #(.COR_EN(1'b0), .CLS_EN(1'b0)) dut_off_i (
        .clk(clk), .rst(rst), .det_ecc_err(ecc), .det_ecc_single(single),
        .det_syn_valid(synv), .det_crc_err(crc), .idle_req(idle_r),
        .inj_strobe(strobe), .inj_addr(addr), .init_done(init_d),
        .cor_done(cor_d), .cor_ok(cok), .cls_done(cls_d), .cls_hit(chit),
        .inj_done(inj_d), .eng_fault(fault), .init_req(b_init_req),
        .cor_req(b_cor_req), .cls_req(b_cls_req), .inj_req(b_inj_req),
        .inj_addr_q(b_addr_q), .evt_single(b_single), .st_init(b_si),
        .st_observe(b_so), .st_correct(b_sc), .st_classify(b_sk),
        .st_inject(b_sj), .heartbeat(b_hb), .flag_uncorr(b_unc),
        .flag_essential(b_ess));

    int checks = 0;
    int fails  = 0;
    bit post_init = 0;
    bit init_again = 0;

    function automatic logic [4:0] vec_a();
        return {a_si, a_so, a_sc, a_sk, a_sj};
    endfunction
    function automatic logic [4:0] vec_b();
        return {b_si, b_so, b_sc, b_sk, b_sj};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    always @(negedge clk) if (post_init && (a_si && !a_so)) init_again = 1;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        step(); step(); step();
        // R1 R2 reset state
        chk(vec_a() == 5'b10000, "R2 reset status", vec_a(), 5'b10000);
        chk(a_init_req && !a_unc && !a_ess && !a_hb, "R2 reset outputs",
            {a_init_req, a_unc, a_ess, a_hb}, 4'b1000);
        rst = 0;
        step(); step();
        chk(vec_a() == 5'b10000, "R2 waits for init_done", vec_a(), 5'b10000);
        init_d = 1; step(); init_d = 0;
        chk(vec_a() == 5'b01000 && vec_b() == 5'b01000, "R2 enter observe",
            vec_a(), 5'b01000);
        post_init = 1;

        // R3 heartbeat in observation
        begin
            int beats = 0;
            bit dbl = 0;
            logic prev = 0;
            for (int i = 0; i < 512; i++) begin
                if (a_hb) beats++;
                if (a_hb && prev) dbl = 1;
                prev = a_hb;
                step();
            end
            chk(beats == 4, "R3 beats per 512", beats, 4);
            chk(!dbl, "R3 one-cycle pulse", dbl, 0);
        end

        // R6..R10 sweep of detection inputs and engine results
        for (int c = 0; c < 64; c++) begin
            bit e = c[0], s = c[1], v = c[2], r = c[3], ok = c[4], hit = c[5];
            bit err = (e && v) || r;
            bit crc_only = r && !(e && v);
            bit exp_unc = crc_only ? 1'b1 : !ok;
            bit exp_ess = crc_only ? 1'b1 : hit;
            ecc = e; single = s; synv = v; crc = r; idle_r = c[1];
            step();
            ecc = 0; single = 0; synv = 0; crc = 0; idle_r = 0;
            if (!err) begin
                chk(vec_a() == 5'b01000 || (idle_r == 0 && vec_a() == 5'b00000),
                    "R6 no error stays", vec_a(), 5'b01000);
                if (vec_a() == 5'b00000) step();
                chk(vec_a() == 5'b01000, "R11 back to observe", vec_a(), 5'b01000);
            end else begin
                chk(vec_a() == 5'b00100 && vec_b() == 5'b00100, "R6 enter correct",
                    vec_a(), 5'b00100);
                chk(a_cor_req == !crc_only && !b_cor_req, "R8 R7 cor_req",
                    a_cor_req, !crc_only);
                chk(a_single == (e && v && s), "R6 single capture", a_single, e && v && s);
                if (!crc_only) begin
                    step();
                    chk(vec_a() == 5'b00100, "R7 waits cor_done", vec_a(), 5'b00100);
                    chk(vec_b() == 5'b00010, "R9 one-cycle correct", vec_b(), 5'b00010);
                    step();
                    chk(vec_b() == 5'b01000, "R9 one-cycle classify", vec_b(), 5'b01000);
                    chk(b_unc && b_ess, "R9 disabled flags", {b_unc, b_ess}, 2'b11);
                    cor_d = 1; cok = ok;
                    step();
                    cor_d = 0; cok = 0;
                    chk(vec_a() == 5'b00010, "R7 enter classify", vec_a(), 5'b00010);
                    chk(a_unc == exp_unc, "R7 uncorr flag", a_unc, exp_unc);
                    chk(a_cls_req, "R10 cls_req", a_cls_req, 1);
                    step();
                    chk(vec_a() == 5'b00010, "R10 waits cls_done", vec_a(), 5'b00010);
                    cls_d = 1; chit = hit;
                    step();
                    cls_d = 0; chit = 0;
                    chk(vec_a() == 5'b01000, "R10 back to observe", vec_a(), 5'b01000);
                    chk(a_ess == exp_ess, "R10 essential flag", a_ess, exp_ess);
                end else begin
                    cor_d = 1; cok = ok;
                    step();
                    cor_d = 0; cok = 0;
                    chk(vec_a() == 5'b00010 && vec_b() == 5'b00010, "R8 one-cycle correct",
                        vec_a(), 5'b00010);
                    chk(a_unc && !a_cls_req && !a_hb, "R8 uncorr set",
                        {a_unc, a_cls_req, a_hb}, 3'b100);
                    cls_d = 1; chit = hit;
                    step();
                    cls_d = 0; chit = 0;
                    chk(vec_a() == 5'b01000 && a_ess, "R8 essential set",
                        {vec_a(), a_ess}, {5'b01000, 1'b1});
                    chk(b_unc && b_ess, "R9 disabled flags crc", {b_unc, b_ess}, 2'b11);
                end
            end
        end

        // R4 R5 R11 injection
        strobe = 1; addr = 36'h123456789;
        step();
        strobe = 0;
        chk(!a_sj && a_addr_q == 36'h0, "R4 strobe ignored in observe", a_addr_q, 0);
        idle_r = 1; step();
        chk(vec_a() == 5'b00000 && vec_b() == 5'b00000, "R11 enter idle", vec_a(), 0);
        strobe = 1; addr = 36'hA5A5_0F0F_3;
        step();
        strobe = 0;
        chk(vec_a() == 5'b00001 && a_inj_req, "R5 inject acknowledged", vec_a(), 5'b00001);
        chk(a_addr_q == 36'hA5A5_0F0F_3, "R4 address captured", a_addr_q, 36'hA5A5_0F0F_3);
        strobe = 1; addr = 36'hF_FFFF_FFFF;
        step(); step();
        strobe = 0;
        chk(a_addr_q == 36'hA5A5_0F0F_3 && a_sj, "R4 strobe ignored in inject",
            a_addr_q, 36'hA5A5_0F0F_3);
        inj_d = 1; step(); inj_d = 0;
        chk(vec_a() == 5'b00000 && !a_inj_req, "R5 inject done to idle", vec_a(), 0);
        idle_r = 0; step();
        chk(vec_a() == 5'b01000, "R11 idle to observe", vec_a(), 5'b01000);

        // R12 halt
        ecc = 1; synv = 1; step(); ecc = 0; synv = 0;
        fault = 1; step(); fault = 0;
        chk(vec_a() == 5'b11111 && vec_b() == 5'b11111, "R12 halted", vec_a(), 5'b11111);
        idle_r = 1; strobe = 1; crc = 1; init_d = 1; inj_d = 1;
        repeat (5) step();
        idle_r = 0; strobe = 0; crc = 0; init_d = 0; inj_d = 0;
        chk(vec_a() == 5'b11111 && !a_hb, "R12 halt sticky R1", vec_a(), 5'b11111);
        chk(!init_again, "R2 init never re-entered", init_again, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule